// File: doc/BRIEF.md
# Failover Takeover Sequencer

This block runs on the standby host at the moment it takes over from a failed primary. One start pulse launches a fixed chain of configuration writes into the switch. The writes travel through the address window that the non-transparent port maps onto the switch's registers. The chain works in a set order. It first takes the upstream role away from the failed host's port. It then gives that role to the local port. It then cuts the failed host off behind a non-transparent role with its link disabled. After that it pulses the secondary reset of the bridge that feeds the downstream devices and clears any transactions still pending. Only then does it ask for re-enumeration.

Every write is a request/acknowledge exchange, and the next write does not begin until the current one is acknowledged. A write left without an acknowledgment for 1024 cycles aborts the chain into a sticky error state. The length of the reset pulse is programmable. A done pulse reports that enumeration has finished and that normal operation can resume.

Top module: `failover_seq`

## Requirements
- R1: After reset, cfg_req_o, enum_req_o, done_o, err_o and busy_o are all low.
- R2: start_i is acted on only in the idle state. A start pulse while a takeover is running, or while in the error state, changes neither the write sequence nor the outputs.
- R3: With the default parameters (window base 0x0010_0000, port stride 0x1000, failed port 0, local port 1), the six writes go out in this order as (address, data): (0x0010_0000, 0x1) to give the failed port the downstream role; (0x0010_1000, 0x0) to give the local port the upstream role; (0x0010_0000, 0x12) to set the failed port to non-transparent role code 2 with link-disable bit 4; (0x0010_003C, 0x0040_0000) to set secondary-reset bit 22 in the failed port's bridge control register; (0x0010_003C, 0x0) to clear that bit; (0x0010_0800, 0x1) to flush, with bit 0 selecting the failed port.
- R4: While cfg_req_o is high and cfg_ack_i has not been sampled high, cfg_addr_o and cfg_data_o hold steady. Each sampled acknowledgment advances the chain by exactly one write.
- R5: hold_cycles_i is captured at start. Between the acknowledgment of the reset-set write and the reset-clear request, cfg_req_o stays low for max(N,1) cycles, where N is the captured value.
- R6: enum_req_o rises only after the flush write is acknowledged and stays high until enum_done_i is sampled. enum_done_i has no effect at any other time, and cfg_req_o is never high together with enum_req_o.
- R7: done_o is high for exactly one cycle, in the cycle after enum_done_i is sampled. The block is idle after that.
- R8: If a request sees no acknowledgment in its first 1024 cycles, cfg_req_o drops and err_o rises and stays high until reset. An acknowledgment sampled in the 1024th cycle is still accepted.
- R9: busy_o is high from the cycle after an accepted start up to and including the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a takeover (single-cycle pulse) |
| hold_cycles_i | input | 8 | Secondary reset length in cycles, captured at start |
| cfg_req_o | output | 1 | Configuration write request |
| cfg_addr_o | output | 32 | Write address inside the switch window |
| cfg_data_o | output | 32 | Write data |
| cfg_ack_i | input | 1 | Write acknowledgment |
| enum_req_o | output | 1 | Re-enumeration request |
| enum_done_i | input | 1 | Re-enumeration finished |
| done_o | output | 1 | Takeover completed (one-cycle pulse) |
| err_o | output | 1 | Sticky acknowledgment-timeout flag |
| busy_o | output | 1 | Takeover in progress |

## Verification
The bench focuses on edge cases that a nearly correct sequencer gets wrong. An acknowledgment arriving in the very last allowed cycle has to be accepted; an off-by-one counter would raise the error flag there instead. A write that is never acknowledged has to raise the error after exactly 1024 cycles, and that error has to survive a later start. Reset lengths of zero and one both have to give a single-cycle gap, and random lengths are checked too; a design that skips the clamp would hold the gap for 256 cycles or none. Start pulses and stray enumeration-done pulses that arrive mid-sequence must not duplicate writes, reorder them or end the chain early.

// File: rtl/failover_pkg.sv
package failover_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEMOTE,
        ST_PROMOTE,
        ST_ISOLATE,
        ST_RST_SET,
        ST_RST_HOLD,
        ST_RST_CLR,
        ST_FLUSH,
        ST_ENUM,
        ST_DONE,
        ST_ERROR
    } seq_state_e;

    localparam logic [1:0] ROLE_UPSTREAM   = 2'd0;
    localparam logic [1:0] ROLE_DOWNSTREAM = 2'd1;
    localparam logic [1:0] ROLE_NONTRANS   = 2'd2;

endpackage

// File: rtl/failover_step_table.sv
module failover_step_table
    import failover_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter logic [31:0] WIN_BASE     = 32'h0010_0000,
    parameter logic [31:0] PORT_STRIDE  = 32'h0000_1000,
    parameter int          FAILED_PORT  = 0,
    parameter int          LOCAL_PORT   = 1,
    parameter logic [31:0] ROLE_OFS     = 32'h0000_0000,
    parameter logic [31:0] BRCTL_OFS    = 32'h0000_003C,
    parameter logic [31:0] FLUSH_OFS    = 32'h0000_0800,
    parameter int          SEC_RST_BIT  = 22,
    parameter int          LINK_DIS_BIT = 4
) (
    input  seq_state_e          state_i,
    output logic                is_write_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [DATA_W-1:0]   data_o
);
    localparam logic [31:0] FAIL_BASE  = WIN_BASE + PORT_STRIDE * FAILED_PORT;
    localparam logic [31:0] LOCAL_BASE = WIN_BASE + PORT_STRIDE * LOCAL_PORT;
    localparam logic [ADDR_W-1:0] A_FAIL_ROLE  = ADDR_W'(FAIL_BASE + ROLE_OFS);
    localparam logic [ADDR_W-1:0] A_LOCAL_ROLE = ADDR_W'(LOCAL_BASE + ROLE_OFS);
    localparam logic [ADDR_W-1:0] A_BRCTL      = ADDR_W'(FAIL_BASE + BRCTL_OFS);
    localparam logic [ADDR_W-1:0] A_FLUSH      = ADDR_W'(WIN_BASE + FLUSH_OFS);
    localparam logic [DATA_W-1:0] D_ONE        = DATA_W'(1);

    always_comb begin
        is_write_o = 1'b1;
        addr_o     = '0;
        data_o     = '0;
        unique case (state_i)
            ST_DEMOTE: begin
                addr_o = A_FAIL_ROLE;
                data_o = DATA_W'(ROLE_DOWNSTREAM);
            end
            ST_PROMOTE: begin
                addr_o = A_LOCAL_ROLE;
                data_o = DATA_W'(ROLE_UPSTREAM);
            end
            ST_ISOLATE: begin
                addr_o = A_FAIL_ROLE;
                data_o = DATA_W'(ROLE_NONTRANS) | (D_ONE << LINK_DIS_BIT);
            end
            ST_RST_SET: begin
                addr_o = A_BRCTL;
                data_o = D_ONE << SEC_RST_BIT;
            end
            ST_RST_CLR: begin
                addr_o = A_BRCTL;
                data_o = '0;
            end
            ST_FLUSH: begin
                addr_o = A_FLUSH;
                data_o = D_ONE << FAILED_PORT;
            end
            default: is_write_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/failover_ack_watchdog.sv
module failover_ack_watchdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ack_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && !ack_i && (cnt_q == LAST);
        if (!run_i || ack_i || expire_o) cnt_d = '0;
        else                             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/failover_seq.sv
module failover_seq
    import failover_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter int          HOLD_W      = 8,
    parameter int          ACK_LIMIT   = 1024,
    parameter logic [31:0] WIN_BASE    = 32'h0010_0000,
    parameter logic [31:0] PORT_STRIDE = 32'h0000_1000,
    parameter int          FAILED_PORT = 0,
    parameter int          LOCAL_PORT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [HOLD_W-1:0] hold_cycles_i,
    output logic              cfg_req_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic [DATA_W-1:0] cfg_data_o,
    input  logic              cfg_ack_i,
    output logic              enum_req_o,
    input  logic              enum_done_i,
    output logic              done_o,
    output logic              err_o,
    output logic              busy_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [HOLD_W-1:0] hold_len;
        logic [HOLD_W-1:0] hold_cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      is_write;
    logic      tmo_expired;

    failover_step_table #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WIN_BASE    (WIN_BASE),
        .PORT_STRIDE (PORT_STRIDE),
        .FAILED_PORT (FAILED_PORT),
        .LOCAL_PORT  (LOCAL_PORT)
    ) u_table (
        .state_i    (r_q.st),
        .is_write_o (is_write),
        .addr_o     (cfg_addr_o),
        .data_o     (cfg_data_o)
    );

    failover_ack_watchdog #(.LIMIT(ACK_LIMIT)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (is_write),
        .ack_i    (cfg_ack_i),
        .expire_o (tmo_expired)
    );

    function automatic seq_state_e after_write(seq_state_e s);
        case (s)
            ST_DEMOTE:  return ST_PROMOTE;
            ST_PROMOTE: return ST_ISOLATE;
            ST_ISOLATE: return ST_RST_SET;
            ST_RST_SET: return ST_RST_HOLD;
            ST_RST_CLR: return ST_FLUSH;
            default:    return ST_ENUM;
        endcase
    endfunction

    always_comb begin
        logic [HOLD_W-1:0] last_cnt;
        r_d      = r_q;
        last_cnt = (r_q.hold_len == '0) ? '0 : r_q.hold_len - 1'b1;
        if (is_write) begin
            if (cfg_ack_i) begin
                r_d.st       = after_write(r_q.st);
                r_d.hold_cnt = '0;
            end else if (tmo_expired) begin
                r_d.st = ST_ERROR;
            end
        end else begin
            case (r_q.st)
                ST_IDLE: if (start_i) begin
                    r_d.st       = ST_DEMOTE;
                    r_d.hold_len = hold_cycles_i;
                end
                ST_RST_HOLD: begin
                    if (r_q.hold_cnt == last_cnt) r_d.st = ST_RST_CLR;
                    else                          r_d.hold_cnt = r_q.hold_cnt + 1'b1;
                end
                ST_ENUM:  if (enum_done_i) r_d.st = ST_DONE;
                ST_DONE:  r_d.st = ST_IDLE;
                default:  r_d.st = r_q.st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, hold_len: '0, hold_cnt: '0};
        else        r_q <= r_d;
    end

    assign cfg_req_o  = is_write;
    assign enum_req_o = (r_q.st == ST_ENUM);
    assign done_o     = (r_q.st == ST_DONE);
    assign err_o      = (r_q.st == ST_ERROR);
    assign busy_o     = (r_q.st != ST_IDLE) && (r_q.st != ST_ERROR);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_o && !cfg_ack_i && !tmo_expired |=>
            cfg_req_o && $stable(cfg_addr_o) && $stable(cfg_data_o));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o && !cfg_req_o);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);
    // R6
    enum_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(enum_req_o && cfg_req_o));
    // R2
    no_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o || err_o);
endmodule

// File: tb/tb_failover_seq.sv
`timescale 1ns/1ps
module tb_failover_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  hold_cycles_i = '0;
    logic        cfg_req_o;
    logic [31:0] cfg_addr_o, cfg_data_o;
    logic        cfg_ack_i = 1'b0;
    logic        enum_req_o;
    logic        model_edone = 1'b0;
    logic        stray_edone = 1'b0;
    logic        enum_done_i;
    logic        done_o, err_o, busy_o;

    assign enum_done_i = model_edone | stray_edone;

    always #4 clk = ~clk;

    failover_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_cycles_i(hold_cycles_i),
        .cfg_req_o(cfg_req_o), .cfg_addr_o(cfg_addr_o), .cfg_data_o(cfg_data_o),
        .cfg_ack_i(cfg_ack_i), .enum_req_o(enum_req_o), .enum_done_i(enum_done_i),
        .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // switch model controls (written by the main process only)
    int  ack_mode = 0;   // 0 random latency, 1 never, 2 fixed
    int  lat_fix  = 0;
    bit  log_clr  = 0;

    // switch model log (written by the model only)
    logic [31:0] wr_addr [16];
    logic [31:0] wr_data [16];
    int  gaps [16];
    int  wr_cnt = 0, gap = 0, done_cnt = 0, enum_cnt = 0, enum_at_wr = -1;
    int  unstable = 0, done_double = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input int i);
        case (i)
            0: return 32'h0010_0000;
            1: return 32'h0010_1000;
            2: return 32'h0010_0000;
            3: return 32'h0010_003C;
            4: return 32'h0010_003C;
            default: return 32'h0010_0800;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input int i);
        case (i)
            0: return 32'h1;
            1: return 32'h0;
            2: return 32'h12;
            3: return 32'h0040_0000;
            4: return 32'h0;
            default: return 32'h1;
        endcase
    endfunction

    function automatic int exp_gap(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    // switch and enumeration model
    initial begin
        bit pending = 0, epend = 0, last_done = 0;
        int cnt = 0, ecnt = 0;
        forever begin
            @(negedge clk);
            cfg_ack_i   = 1'b0;
            model_edone = 1'b0;
            if (log_clr) begin
                wr_cnt = 0; gap = 0; done_cnt = 0; enum_cnt = 0; enum_at_wr = -1;
                unstable = 0; done_double = 0; pending = 0; epend = 0;
            end
            if (cfg_req_o) begin
                if (!pending) begin
                    pending = 1;
                    cnt = (ack_mode == 2) ? lat_fix : $urandom_range(0, 7);
                    if (wr_cnt < 16) begin
                        wr_addr[wr_cnt] = cfg_addr_o;
                        wr_data[wr_cnt] = cfg_data_o;
                        gaps[wr_cnt]    = gap;
                    end
                    wr_cnt++;
                end else if (wr_cnt <= 16 &&
                             (cfg_addr_o != wr_addr[wr_cnt-1] || cfg_data_o != wr_data[wr_cnt-1])) begin
                    unstable++;
                end
                if (ack_mode != 1) begin
                    if (cnt == 0) begin cfg_ack_i = 1'b1; pending = 0; end
                    else cnt--;
                end
                gap = 0;
            end else begin
                pending = 0;
                gap++;
            end
            if (enum_req_o) begin
                if (!epend) begin
                    epend = 1; ecnt = $urandom_range(0, 5);
                    enum_cnt++; enum_at_wr = wr_cnt;
                end
                if (ecnt == 0) begin model_edone = 1'b1; epend = 0; end
                else ecnt--;
            end
            if (done_o) begin
                done_cnt++;
                if (last_done) done_double++;
            end
            last_done = done_o;
        end
    end

    task automatic clear_log();
        @(posedge clk); log_clr = 1;
        @(negedge clk); @(posedge clk); log_clr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    task automatic run_seq(input int hold, input bit inject, input string tag);
        int guard = 0;
        clear_log();
        hold_cycles_i = 8'(hold);
        pulse_start();
        // R9: busy in the cycle after the accepted start
        chk(busy_o === 1'b1, {"R9 busy after start ", tag}, busy_o, 1);
        hold_cycles_i = 8'($urandom_range(0, 255));
        if (inject) begin
            while (wr_cnt < 3 && guard < 3000) begin @(negedge clk); guard++; end
            start_i = 1; stray_edone = 1;          // R2 / R6 stray inputs mid-run
            @(negedge clk); start_i = 0; stray_edone = 0;
        end
        while (done_cnt == 0 && guard < 20000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
        chk(wr_cnt == 6, {"R3 write count ", tag}, wr_cnt, 6);
        for (int i = 0; i < 6; i++) begin
            chk(wr_addr[i] == exp_addr(i), {"R3 addr ", tag}, wr_addr[i], exp_addr(i));
            chk(wr_data[i] == exp_data(i), {"R3 data ", tag}, wr_data[i], exp_data(i));
        end
        chk(unstable == 0, {"R4 stable request ", tag}, unstable, 0);
        chk(gaps[4] == exp_gap(hold), {"R5 reset gap ", tag}, gaps[4], exp_gap(hold));
        chk(enum_cnt == 1 && enum_at_wr == 6, {"R6 enum after flush ", tag}, enum_at_wr, 6);
        chk(done_cnt == 1 && done_double == 0, {"R7 single done ", tag}, done_cnt, 1);
        chk(busy_o === 1'b0 && err_o === 1'b0, {"R9 idle after done ", tag}, busy_o, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<=150000", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        chk({cfg_req_o, enum_req_o, done_o, err_o, busy_o} === 5'b0, "R1 reset state",
            {cfg_req_o, enum_req_o, done_o, err_o, busy_o}, 0);

        // R6 stray enum_done while idle has no effect
        stray_edone = 1; @(negedge clk); stray_edone = 0; @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R6 stray done idle", busy_o, 0);

        // directed: reset length corner cases
        ack_mode = 0;
        run_seq(0, 0, "hold0");
        run_seq(1, 0, "hold1");
        run_seq(255, 0, "hold255");
        run_seq(9, 1, "inject");

        // random runs
        for (int k = 0; k < 6; k++) run_seq($urandom_range(0, 20), k[0], "rand");

        // R8 boundary: acknowledgment in the 1024th cycle is accepted
        ack_mode = 2; lat_fix = 1023;
        run_seq(3, 0, "R8 late ack");
        chk(err_o === 1'b0, "R8 late ack no error", err_o, 0);

        // R8 timeout: never acknowledged
        ack_mode = 1;
        clear_log();
        hold_cycles_i = 8'd2;
        pulse_start();
        repeat (1023) @(negedge clk);
        chk(err_o === 1'b0 && cfg_req_o === 1'b1, "R8 still waiting at 1023", err_o, 0);
        @(negedge clk);
        chk(err_o === 1'b1, "R8 error at 1024", err_o, 1);
        chk(cfg_req_o === 1'b0 && busy_o === 1'b0, "R8 request dropped", cfg_req_o, 0);
        // R2 start ignored in error state
        ack_mode = 0;
        pulse_start();
        repeat (10) @(negedge clk);
        chk(err_o === 1'b1 && cfg_req_o === 1'b0 && busy_o === 1'b0 && wr_cnt == 1,
            "R2 start ignored in error", wr_cnt, 1);
        do_reset();
        @(negedge clk);
        chk(err_o === 1'b0 && busy_o === 1'b0, "R1 reset clears error", err_o, 0);
        run_seq(5, 0, "after error");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule